// File: doc/BRIEF.md
# Read-Address Command Sequence Detector

This block watches the stream of completed accesses to a memory and picks out one fixed chain of six reads. Each access is reported for one cycle on a strobe, together with its direction and its address. The first five reads of the chain share a fixed prefix. The address of the sixth read selects one of four device commands: nonvolatile store, nonvolatile recall, disable automatic store, or enable automatic store. The chosen command leaves the block as a single-cycle pulse.

Matching uses only the low 16 bits of the address, whatever the address width. Any write breaks a chain that is in progress. So does any read that does not match the next expected address. A read that breaks a chain is compared again with the first prefix address, so a new chain can start on that read. The block has no notion of read strobing, so a read counts whether or not the output drivers were enabled. While the external busy input is high, accesses are ignored and the chain position is kept.

Top module: `rd_cmd_seq_det`

## Requirements
- R1: After reset all four command outputs are low and the detector is idle, so a lone read of a command address issues nothing.
- R2: Reads of 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, in that order, followed by a read of 0x8FC0 raise `store_o` for exactly one cycle. The pulse is high in the cycle after the clock edge that accepts the sixth read.
- R3: The same five-read prefix followed by a read of 0x4C63 raises `recall_o` for one cycle, with the same timing as R2.
- R4: The prefix followed by a read of 0x8B45 raises `auto_off_o`. The prefix followed by a read of 0x4B46 raises `auto_on_o`. Each pulse lasts one cycle, with the same timing as R2.
- R5: Address bits at position 16 and above take no part in matching. A chain whose reads carry nonzero upper bits still issues its command.
- R6: An accepted write at any point aborts the chain. The remaining reads of the chain then issue no command.
- R7: A read that does not match the next step aborts the chain. If that read is 0x4E38, it counts as the first step of a new chain.
- R8: A sixth read that matches none of the four command addresses issues nothing and leaves the detector idle.
- R9: Cycles without an access strobe between the reads of a chain do not disturb it.
- R10: An access made while `busy_i` is high is ignored. It neither advances nor aborts the chain and issues no command.
- R11: At most one command output is high in any cycle. After a command the detector is idle, so repeating only the sixth read issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | One-cycle strobe for a completed access |
| acc_write_i | input | 1 | High when the access is a write, low when it is a read |
| acc_addr_i | input | ADDR_W | Address of the access |
| busy_i | input | 1 | High while a command runs; accesses are ignored |
| store_o | output | 1 | Pulse: nonvolatile store command |
| recall_o | output | 1 | Pulse: nonvolatile recall command |
| auto_off_o | output | 1 | Pulse: disable automatic store |
| auto_on_o | output | 1 | Pulse: enable automatic store |

## Verification
The bench builds the block with ADDR_W set to 20, four bits wider than the 16-bit match key. This lets it drive nonzero upper address bits and show that a chain still completes (R5). With the default width of 18 that case would be reached with only two spare bits. Every other parameter is fixed by the command protocol. The scenarios therefore cover chain orderings rather than sizes: abort at each kind of break, restart on the breaking read, idle gaps, and busy windows in the middle and at the last step.

// File: rtl/rd_cmd_seq_pkg.sv
package rd_cmd_seq_pkg;
  localparam int KEY_W      = 16;
  localparam int PREFIX_LEN = 5;
  localparam int NUM_CMD    = 4;

  typedef enum logic [1:0] {
    CMD_STORE    = 2'd0,
    CMD_RECALL   = 2'd1,
    CMD_AUTO_OFF = 2'd2,
    CMD_AUTO_ON  = 2'd3
  } cmd_e;

  function automatic logic [KEY_W-1:0] prefix_key(input int idx);
    case (idx)
      0:       return 16'h4E38;
      1:       return 16'hB1C7;
      2:       return 16'h83E0;
      3:       return 16'h7C1F;
      default: return 16'h703F;
    endcase
  endfunction

  function automatic logic [KEY_W-1:0] cmd_key(input int idx);
    case (idx)
      int'(CMD_STORE):    return 16'h8FC0;
      int'(CMD_RECALL):   return 16'h4C63;
      int'(CMD_AUTO_OFF): return 16'h8B45;
      default:            return 16'h4B46;
    endcase
  endfunction
endpackage

// File: rtl/rd_seq_match.sv
module rd_seq_match
  import rd_cmd_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic              adv_o,
  output logic              first_hit_o,
  output logic [NUM_CMD-1:0] cmd_hit_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PREFIX_LEN);

  always_comb begin
    adv_o = 1'b0;
    if (step_i < LAST_STEP) adv_o = (key_i == prefix_key(int'(step_i)));
  end

  assign first_hit_o = (key_i == prefix_key(0));

  for (genvar c = 0; c < NUM_CMD; c++) begin : g_cmd
    assign cmd_hit_o[c] = (step_i == LAST_STEP) && (key_i == cmd_key(c));
  end
endmodule

// File: rtl/rd_seq_state.sv
module rd_seq_state
  import rd_cmd_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              write_i,
  input  logic              adv_i,
  input  logic              first_hit_i,
  output logic [STEP_W-1:0] step_o
);
  logic [STEP_W-1:0] step_d;

  always_comb begin
    step_d = step_o;
    if (take_i) begin
      if (write_i)          step_d = '0;
      else if (adv_i)       step_d = step_o + STEP_W'(1);
      else if (first_hit_i) step_d = STEP_W'(1); // restart on breaking read
      else                  step_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_o <= '0;
    else         step_o <= step_d;
  end
endmodule

// File: rtl/rd_cmd_pulse.sv
module rd_cmd_pulse
  import rd_cmd_seq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic [NUM_CMD-1:0] hit_i,
  output logic [NUM_CMD-1:0] pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= '0;
    else         pulse_o <= fire_i ? hit_i : '0;
  end
endmodule

// File: rtl/rd_cmd_seq_det.sv
module rd_cmd_seq_det
  import rd_cmd_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              busy_i,
  output logic              store_o,
  output logic              recall_o,
  output logic              auto_off_o,
  output logic              auto_on_o
);
  localparam int STEP_W = $clog2(PREFIX_LEN + 1);

  logic [KEY_W-1:0]   key;
  logic [STEP_W-1:0]  step_q;
  logic               take, adv, first_hit;
  logic [NUM_CMD-1:0] cmd_hit, cmd_q;

  assign key  = acc_addr_i[KEY_W-1:0];
  assign take = acc_valid_i && !busy_i;

  if (ADDR_W > KEY_W) begin : g_hi
    logic unused_hi_bits;
    assign unused_hi_bits = ^acc_addr_i[ADDR_W-1:KEY_W];
  end

  rd_seq_match #(.STEP_W(STEP_W)) match_i (
    .step_i      (step_q),
    .key_i       (key),
    .adv_o       (adv),
    .first_hit_o (first_hit),
    .cmd_hit_o   (cmd_hit)
  );

  rd_seq_state #(.STEP_W(STEP_W)) state_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (take),
    .write_i     (acc_write_i),
    .adv_i       (adv),
    .first_hit_i (first_hit),
    .step_o      (step_q)
  );

  rd_cmd_pulse pulse_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (take && !acc_write_i),
    .hit_i   (cmd_hit),
    .pulse_o (cmd_q)
  );

  assign store_o    = cmd_q[CMD_STORE];
  assign recall_o   = cmd_q[CMD_RECALL];
  assign auto_off_o = cmd_q[CMD_AUTO_OFF];
  assign auto_on_o  = cmd_q[CMD_AUTO_ON];
endmodule

// File: rtl/rd_cmd_seq_det_chk.sv
module rd_cmd_seq_det_chk #(
  parameter int ADDR_W = 18,
  parameter int STEP_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_valid_i,
  input logic              acc_write_i,
  input logic              busy_i,
  input logic [STEP_W-1:0] step_i,
  input logic              store_o,
  input logic              recall_o,
  input logic              auto_off_o,
  input logic              auto_on_o
);
  logic [3:0] cmds;
  assign cmds = {auto_on_o, auto_off_o, recall_o, store_o};

  // R11
  cmd_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmds));

  // R11
  cmd_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmds != 4'b0) |=> (cmds == 4'b0));

  // R6
  write_no_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i) |=> (cmds == 4'b0));

  // R10
  busy_no_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (cmds == 4'b0));

  // R10
  busy_hold_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(step_i));

  // R9
  idle_hold_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> $stable(step_i));

  // R11
  cmd_returns_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmds != 4'b0) |-> (step_i == '0));

  // R1
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i <= STEP_W'(5));
endmodule

bind rd_cmd_seq_det rd_cmd_seq_det_chk #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_write_i (acc_write_i),
  .busy_i      (busy_i),
  .step_i      (step_q),
  .store_o     (store_o),
  .recall_o    (recall_o),
  .auto_off_o  (auto_off_o),
  .auto_on_o   (auto_on_o)
);

// File: tb/rd_cmd_seq_det_tb_top.sv
`timescale 1ns/1ps
module rd_cmd_seq_det_tb_top;
  localparam int AW = 20;
  localparam int NONE = 0, ST = 1, RC = 2, OFF = 3, ON = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0, wr = 1'b0, busy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          store, recall, aoff, aon;
  int            n_chk = 0, n_err = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  rd_cmd_seq_det #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_write_i(wr),
    .acc_addr_i(addr), .busy_i(busy), .store_o(store), .recall_o(recall),
    .auto_off_o(aoff), .auto_on_o(aon)
  );

  function automatic int seen();
    logic [3:0] v;
    v = {aon, aoff, recall, store};
    case (v)
      4'b0000: return NONE;
      4'b0001: return ST;
      4'b0010: return RC;
      4'b0100: return OFF;
      4'b1000: return ON;
      default: return 99;
    endcase
  endfunction

  task automatic check(input int exp, input string req);
    int got;
    got = seen();
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: command got %0d expected %0d", req, got, exp);
    end
  endtask

  // one access in one cycle; outputs sampled after the accepting edge
  task automatic acc(input logic [15:0] a, input logic w, input logic b,
                     input int exp, input string req, input logic [3:0] hi = 4'h0);
    @(negedge clk);
    valid = 1'b1; wr = w; busy = b; addr = {hi, a};
    @(negedge clk);
    valid = 1'b0; wr = 1'b0; busy = 1'b0;
    check(exp, req);
  endtask

  task automatic prefix(input string req, input logic [3:0] hi = 4'h0);
    acc(16'h4E38, 0, 0, NONE, req, hi);
    acc(16'hB1C7, 0, 0, NONE, req, hi);
    acc(16'h83E0, 0, 0, NONE, req, hi);
    acc(16'h7C1F, 0, 0, NONE, req, hi);
    acc(16'h703F, 0, 0, NONE, req, hi);
  endtask

  task automatic t_reset();
    check(NONE, "R1");
    acc(16'h8FC0, 0, 0, NONE, "R1");
  endtask

  task automatic t_store();
    prefix("R2");
    acc(16'h8FC0, 0, 0, ST, "R2");
    @(negedge clk); check(NONE, "R2");
  endtask

  task automatic t_recall();
    prefix("R3");
    acc(16'h4C63, 0, 0, RC, "R3");
  endtask

  task automatic t_auto();
    prefix("R4");
    acc(16'h8B45, 0, 0, OFF, "R4");
    prefix("R4");
    acc(16'h4B46, 0, 0, ON, "R4");
  endtask

  task automatic t_upper();
    prefix("R5", 4'hA);
    acc(16'h8FC0, 0, 0, ST, "R5", 4'h5);
  endtask

  task automatic t_write_abort();
    acc(16'h4E38, 0, 0, NONE, "R6");
    acc(16'hB1C7, 0, 0, NONE, "R6");
    acc(16'h83E0, 1, 0, NONE, "R6");
    acc(16'h83E0, 0, 0, NONE, "R6");
    acc(16'h7C1F, 0, 0, NONE, "R6");
    acc(16'h703F, 0, 0, NONE, "R6");
    acc(16'h8FC0, 0, 0, NONE, "R6");
    prefix("R6");
    acc(16'h4C63, 1, 0, NONE, "R6");
    acc(16'h4C63, 0, 0, NONE, "R6");
  endtask

  task automatic t_mismatch();
    acc(16'h4E38, 0, 0, NONE, "R7");
    acc(16'hB1C7, 0, 0, NONE, "R7");
    acc(16'h1234, 0, 0, NONE, "R7");
    acc(16'h83E0, 0, 0, NONE, "R7");
    acc(16'h7C1F, 0, 0, NONE, "R7");
    acc(16'h703F, 0, 0, NONE, "R7");
    acc(16'h8FC0, 0, 0, NONE, "R7");
    // breaking read equal to first key restarts
    acc(16'h4E38, 0, 0, NONE, "R7");
    acc(16'hB1C7, 0, 0, NONE, "R7");
    acc(16'h4E38, 0, 0, NONE, "R7");
    acc(16'hB1C7, 0, 0, NONE, "R7");
    acc(16'h83E0, 0, 0, NONE, "R7");
    acc(16'h7C1F, 0, 0, NONE, "R7");
    acc(16'h703F, 0, 0, NONE, "R7");
    acc(16'h8FC0, 0, 0, ST, "R7");
  endtask

  task automatic t_bad_sixth();
    prefix("R8");
    acc(16'h1111, 0, 0, NONE, "R8");
    acc(16'h8FC0, 0, 0, NONE, "R8");
  endtask

  task automatic t_gaps();
    acc(16'h4E38, 0, 0, NONE, "R9");
    repeat (3) @(negedge clk);
    acc(16'hB1C7, 0, 0, NONE, "R9");
    acc(16'h83E0, 0, 0, NONE, "R9");
    repeat (5) @(negedge clk);
    acc(16'h7C1F, 0, 0, NONE, "R9");
    acc(16'h703F, 0, 0, NONE, "R9");
    repeat (2) @(negedge clk);
    acc(16'h4C63, 0, 0, RC, "R9");
  endtask

  task automatic t_busy();
    acc(16'h4E38, 0, 0, NONE, "R10");
    acc(16'hB1C7, 0, 0, NONE, "R10");
    acc(16'h9999, 0, 1, NONE, "R10");
    acc(16'h0000, 1, 1, NONE, "R10");
    acc(16'h83E0, 0, 0, NONE, "R10");
    acc(16'h7C1F, 0, 0, NONE, "R10");
    acc(16'h703F, 0, 0, NONE, "R10");
    acc(16'h8FC0, 0, 1, NONE, "R10");
    acc(16'h8B45, 0, 0, OFF, "R10");
  endtask

  task automatic t_repeat();
    prefix("R11");
    acc(16'h4B46, 0, 0, ON, "R11");
    acc(16'h4B46, 0, 0, NONE, "R11");
    acc(16'h8FC0, 0, 0, NONE, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_store();
    t_recall();
    t_auto();
    t_upper();
    t_write_abort();
    t_mismatch();
    t_bad_sixth();
    t_gaps();
    t_busy();
    t_repeat();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule